// File: doc/BRIEF.md
# LED Blink Generator with Auto-Stop

This block drives one LED pin with a programmable blink waveform. A free-running prescaler produces a tick at a rate chosen by a four-bit power-of-two select. Each tick advances an in-period counter. The counter runs from zero up to a programmed period value and then starts over. The LED is lit while the counter is below a programmed on-time value.

An optional auto-stop mode counts completed periods against a programmed limit. When the last period completes, the generator switches itself off and sets a sticky completion flag. The flag drives an interrupt output unless the interrupt is masked.

Software controls the block through four word-aligned registers on a simple write strobe interface. Reads are combinational. Word offsets are selected by address bits [3:2], and address bits [1:0] are ignored.

Top module: `led_blink_gen`

## Requirements
- R1: Four registers are decoded by addr[3:2]:
  - 0x0 is control, 7 bits: [3:0] rate, [4] enable, [5] auto-stop, [6] interrupt mask.
  - 0x4 is period, 12 bits.
  - 0x8 is on-time, 12 bits.
  - 0xC is stop count, 16 bits.
  - Each register reads back what was written. Bits above each register's width read as zero.
- R2: For a rate value n from 0 to 13, a tick occurs once every 2^(13-n) clocks. Rate values 14 and 15 behave like 13, which gives a tick on every clock.
- R3: With the enable bit clear, the LED is low and the in-period counter is held at zero. After a control write that sets enable, the counter starts at zero on the following cycle.
- R4: On each tick while enabled, the counter increments. On a tick at which the counter is greater than or equal to the period value, it returns to zero instead, completing a period. A period therefore lasts period+1 ticks.
- R5: While enabled, the LED is high exactly when the counter is below the on-time value. An on-time of 0 keeps the LED low. An on-time greater than the period keeps the LED high.
- R6: Auto-stop behaviour:
  - A remaining-periods copy is loaded from the stop count whenever the control or stop-count register is written.
  - With auto-stop set, each completed period decrements the copy.
  - The period that completes with a copy of 1 or 0 clears the enable bit and sets the done flag. A count of 0 therefore stops after one period.
- R7: The interrupt output equals the done flag when the mask bit is 0. It is low when the mask bit is 1.
- R8: Any write to the control register clears the done flag. Otherwise the flag holds its value. A control write takes precedence over a stop completing in the same cycle.
- R9: After synchronous reset, all registers and the done flag are zero, and the LED and interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte address; bits [3:2] select the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for addr |
| led_out | output | 1 | LED drive |
| irq | output | 1 | Auto-stop completion interrupt |

## Verification
The hardest situation to reach from the ports is the exact cycle at which auto-stop ends a run. At that moment the enable bit self-clears, the LED goes low and the interrupt rises. The bench selects a rate of 13 or above, so every clock is a tick. This makes the stop cycle equal to count×(period+1) after the control write, and the scoreboard predicts every cycle around it. A count of zero and the masked-interrupt case are driven the same way, and a control write after the stop shows that the flag clears.

// File: rtl/lbg_pkg.sv
package lbg_pkg;

    localparam int MAX_SHIFT = 13;
    localparam int RATE_W    = 4;
    localparam int PER_W     = 12;
    localparam int CNT_W     = 16;
    localparam int DATA_W    = 16;
    localparam int CTRL_W    = 7;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_PER  = 2'd1,
        REG_ON   = 2'd2,
        REG_STOP = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              irq_mask;
        logic              auto_stop;
        logic              enable;
        logic [RATE_W-1:0] rate;
    } ctrl_t;

    // number of prescaler bits that must be all ones for a tick
    function automatic int tick_shift(logic [RATE_W-1:0] rate, int max_shift);
        if (int'(rate) >= max_shift) return 0;
        return max_shift - int'(rate);
    endfunction

endpackage

// File: rtl/lbg_prescaler.sv
module lbg_prescaler
    import lbg_pkg::*;
#(
    parameter int MAXS = lbg_pkg::MAX_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [MAXS-1:0] div_q;
    logic [MAXS-1:0] need;
    int              shift;

    assign shift = tick_shift(rate, MAXS);

    for (genvar g = 0; g < MAXS; g++) begin : g_need
        assign need[g] = (g < shift);
    end

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    assign tick = &(div_q | ~need);

    // a slower rate never ticks twice in a row
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && shift != 0 && $stable(rate)) |=> !tick);

endmodule

// File: rtl/lbg_regs.sv
module lbg_regs
    import lbg_pkg::*;
#(
    parameter int PW = lbg_pkg::PER_W,
    parameter int CW = lbg_pkg::CNT_W,
    parameter int DW = lbg_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [3:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic          stop_req,
    output ctrl_t         ctrl,
    output logic [PW-1:0] period,
    output logic [PW-1:0] on_time,
    output logic [CW-1:0] stop_cnt,
    output logic          load_remain,
    output logic          done,
    output logic [DW-1:0] rdata
);
    reg_sel_e sel;
    logic     ctrl_wr;

    assign sel         = reg_sel_e'(addr[3:2]);
    assign ctrl_wr     = wr_en && (sel == REG_CTRL);
    assign load_remain = wr_en && (sel == REG_CTRL || sel == REG_STOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            period   <= '0;
            on_time  <= '0;
            stop_cnt <= '0;
            done     <= 1'b0;
        end else begin
            if (stop_req) begin
                ctrl.enable <= 1'b0;
                done        <= 1'b1;
            end
            if (wr_en) begin
                unique case (sel)
                    REG_CTRL: begin
                        ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
                        done <= 1'b0;
                    end
                    REG_PER:  period   <= wdata[PW-1:0];
                    REG_ON:   on_time  <= wdata[PW-1:0];
                    REG_STOP: stop_cnt <= wdata[CW-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            REG_CTRL: rdata[CTRL_W-1:0] = ctrl;
            REG_PER:  rdata[PW-1:0]     = period;
            REG_ON:   rdata[PW-1:0]     = on_time;
            REG_STOP: rdata[CW-1:0]     = stop_cnt;
            default:  rdata             = '0;
        endcase
    end

    p_stop_clears_en_r6: assert property (@(posedge clk) disable iff (rst)
        (stop_req && !ctrl_wr) |=> (!ctrl.enable && done));
    p_ctrl_wr_clears_done_r8: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> !done);
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !ctrl_wr) |=> done);

endmodule

// File: rtl/lbg_wave.sv
module lbg_wave
    import lbg_pkg::*;
#(
    parameter int PW = lbg_pkg::PER_W,
    parameter int CW = lbg_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          auto_stop,
    input  logic          tick,
    input  logic [PW-1:0] period,
    input  logic [PW-1:0] on_time,
    input  logic [CW-1:0] stop_cnt,
    input  logic          load_remain,
    output logic          led,
    output logic          stop_req
);
    logic [PW-1:0] pos_q;
    logic [CW-1:0] remain_q;
    logic          wrap;
    logic          last;

    assign wrap     = en && tick && (pos_q >= period);
    assign last     = (remain_q <= CW'(1));
    assign stop_req = wrap && auto_stop && last;
    assign led      = en && (pos_q < on_time);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= '0;
            remain_q <= '0;
        end else begin
            if (!en)       pos_q <= '0;
            else if (tick) pos_q <= wrap ? '0 : pos_q + 1'b1;

            if (load_remain)
                remain_q <= stop_cnt;
            else if (wrap && auto_stop)
                remain_q <= last ? '0 : remain_q - 1'b1;
        end
    end

    p_hold_zero_r3: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pos_q == '0));
    p_wrap_to_zero_r4: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (pos_q == '0));
    p_remain_load_r6: assert property (@(posedge clk) disable iff (rst)
        load_remain |=> (remain_q == $past(stop_cnt)));

endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen
    import lbg_pkg::*;
#(
    parameter int PER_W  = lbg_pkg::PER_W,
    parameter int CNT_W  = lbg_pkg::CNT_W,
    parameter int DATA_W = lbg_pkg::DATA_W,
    parameter int MAXS   = lbg_pkg::MAX_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              led_out,
    output logic              irq
);
    ctrl_t             ctrl;
    logic [PER_W-1:0]  period;
    logic [PER_W-1:0]  on_time;
    logic [CNT_W-1:0]  stop_cnt;
    logic              load_remain;
    logic              done;
    logic              stop_req;
    logic              tick;

    lbg_regs #(.PW(PER_W), .CW(CNT_W), .DW(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .stop_req(stop_req), .ctrl(ctrl), .period(period), .on_time(on_time),
        .stop_cnt(stop_cnt), .load_remain(load_remain), .done(done),
        .rdata(rdata)
    );

    lbg_prescaler #(.MAXS(MAXS)) u_pre (
        .clk(clk), .rst(rst), .rate(ctrl.rate), .tick(tick)
    );

    lbg_wave #(.PW(PER_W), .CW(CNT_W)) u_wave (
        .clk(clk), .rst(rst), .en(ctrl.enable), .auto_stop(ctrl.auto_stop),
        .tick(tick), .period(period), .on_time(on_time), .stop_cnt(stop_cnt),
        .load_remain(load_remain), .led(led_out), .stop_req(stop_req)
    );

    assign irq = done && !ctrl.irq_mask;

    // the LED never lights in the cycle after the generator stopped itself
    p_stop_darkens_led_r6: assert property (@(posedge clk) disable iff (rst)
        (stop_req && !(wr_en && addr[3:2] == 2'd0)) |=> !led_out);

endmodule

// File: tb/sim_led_blink_gen.sv
module sim_led_blink_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        led_out;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    bit    q_led[$];
    bit    q_irq[$];
    string q_tag[$];

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    led_blink_gen u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .led_out(led_out), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected outputs and compares just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_led.size() > 0) begin
                automatic bit    el = q_led.pop_front();
                automatic bit    ei = q_irq.pop_front();
                automatic string t  = q_tag.pop_front();
                check(led_out == el, {t, " led"}, led_out, el);
                check(irq == ei, {t, " irq"}, irq, ei);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [3:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        check(rdata == exp, tag, rdata, exp);
    endtask

    // driver: configure, then write control and push the predicted waveform
    task automatic run(input int rate, input int per, input int on, input int cnt,
                       input bit en, input bit as, input bit msk, input int ncyc,
                       input string tag);
        int kp;
        int stop_at;
        wr(4'h4, 16'(per));
        wr(4'h8, 16'(on));
        wr(4'hC, 16'(cnt));
        kp      = (cnt == 0) ? 1 : cnt;
        stop_at = kp * (per + 1);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'h0;
        wdata = 16'((int'(msk) << 6) | (int'(as) << 5) | (int'(en) << 4) | rate);
        for (int i = 0; i < ncyc; i++) begin
            if (!en) begin
                q_led.push_back(1'b0); q_irq.push_back(1'b0);
            end else if (as && i >= stop_at) begin
                q_led.push_back(1'b0); q_irq.push_back(!msk);
            end else begin
                q_led.push_back((i % (per + 1)) < on); q_irq.push_back(1'b0);
            end
            q_tag.push_back(tag);
        end
        @(negedge clk);
        wr_en = 1'b0;
        while (q_led.size() > 0) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected done", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int r1;
        int r2;
        bit prev;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        #1;
        check(led_out == 1'b0, "R9 led", led_out, 0);
        check(irq == 1'b0, "R9 irq", irq, 0);
        rd_check(4'h0, 16'h0, "R9 ctrl");
        rd_check(4'h4, 16'h0, "R9 period");
        rd_check(4'hC, 16'h0, "R9 count");

        // R1 register widths and readback
        wr(4'h0, 16'hFF4D);
        rd_check(4'h0, 16'h004D, "R1 ctrl");
        wr(4'h4, 16'hFFFF);
        rd_check(4'h4, 16'h0FFF, "R1 period");
        wr(4'h8, 16'hF123);
        rd_check(4'h8, 16'h0123, "R1 on-time");
        wr(4'hC, 16'hBEEF);
        rd_check(4'hC, 16'hBEEF, "R1 count");
        wr(4'h0, 16'h0);

        // R4 R5 free run, tick every clock
        run(13, 5, 2, 0, 1, 0, 0, 40, "R4 free run p5 d2");
        run(13, 4, 0, 0, 1, 0, 0, 15, "R5 on-time zero");
        run(13, 3, 9, 0, 1, 0, 0, 15, "R5 on-time above period");
        // R3 disabled output stays low
        run(13, 3, 9, 0, 0, 0, 0, 12, "R3 disabled");
        // R2 clamp of rates above 13
        run(15, 2, 1, 0, 1, 0, 0, 18, "R2 rate 15");

        // R6 R7 auto-stop with interrupt
        wr(4'h0, 16'h0);
        run(13, 3, 1, 3, 1, 1, 0, 20, "R6 auto-stop k3");
        rd_check(4'h0, 16'h002D, "R6 enable self-cleared");
        // R8 control write clears done
        wr(4'h0, 16'h000D);
        #3;
        check(irq == 1'b0, "R8 done cleared", irq, 0);

        // R6 count zero stops after one period, R7 masked
        run(13, 2, 2, 0, 1, 1, 1, 10, "R7 masked k0");
        wr(4'h0, 16'h0);

        // R2 rate 11: one tick per 4 clocks, period 2 ticks -> rise every 8 clocks
        wr(4'h4, 16'd1);
        wr(4'h8, 16'd1);
        wr(4'h0, 16'h001B);
        repeat (10) @(negedge clk);
        prev = led_out; r1 = -1; r2 = -1;
        for (int k = 0; k < 40 && r2 < 0; k++) begin
            @(negedge clk);
            if (led_out && !prev) begin
                if (r1 < 0) r1 = cyc; else r2 = cyc;
            end
            prev = led_out;
        end
        check(r2 - r1 == 8, "R2 rate 11 spacing", r2 - r1, 8);
        wr(4'h0, 16'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule